// File: doc/BRIEF.md
# Multi-level vectored interrupt controller

This controller sits beside an 8-bit processor core and collects eight interrupt requests: four active-low external pins, two timer rollovers, a serial port (receive or transmit) and a third timer (overflow or external event). Each source has an enable bit and a two-bit priority. The priority gives four nesting levels. A global enable gates all of them. Each cycle the controller picks one winner. Among pending and enabled sources the highest level wins. Within a level a fixed polling order decides. The controller may vector only when the winner's level is strictly above every level now in service.

On a grant the controller raises a one-cycle vector request and presents an 8-bit vector address. It then holds that address and waits for the core's acknowledge pulse. On the acknowledge it marks the level as in service and clears the source flag by that source's own rule. A return-from-interrupt pulse retires the highest level in service. Software reaches every enable, priority, mode and flag bit through a small register port. The port writes on a strobe and reads combinationally.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `vec_req` is low and every register address (0 to 5) reads 0. All external inputs start in level mode.
- R2: Register map:
  - Address 0 holds the source enables. Bit i is source i, in polling order.
  - Address 1 bit 7 is the global enable. Bits 3:0 select edge mode (1) or level mode (0) for external inputs 0 to 3.
  - Address 2 holds the low priority bit per source. Address 3 holds the high priority bit. The level of source i is {addr3[i], addr2[i]}.
  - Address 4 holds the request flags: bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial receive, bit5 serial transmit, bit6 ext2, bit7 ext3.
  - Address 5 holds bit0 timer2 overflow and bit1 timer2 external.
  - A write lands at the clock edge. A read returns the stored value.
- R3: No vector request is raised while the global enable is 0. A source whose enable bit is 0 is never granted.
- R4: When sources of different levels are pending, the one with the highest level is granted, whatever its polling position.
- R5: Within one level, the lowest source index wins. Source i vectors to address 8*i+3: ext0 03h, timer0 0Bh, ext1 13h, timer1 1Bh, serial 23h, timer2 2Bh, ext2 33h, ext3 3Bh.
- R6: A request is granted only if its level is strictly above every level in service. A `reti` pulse clears the highest in-service level.
- R7: `vec_req` is high for exactly one cycle. No further request is raised until `vec_ack`. Flag clearing and the in-service mark happen only on `vec_ack`.
- R8: In edge mode, a falling edge of an external pin sets its flag. Acknowledging that source clears the flag. A pin held low raises no further request.
- R9: In level mode, an external flag reads 1 exactly while the synchronized pin is low. Acknowledging does not clear it, and a software write to it has no effect.
- R10: A timer0 or timer1 pulse sets its flag, and acknowledging that source clears it. A pulse in the same cycle as the acknowledge leaves the flag set.
- R11: The serial request is receive OR transmit, and the timer2 request is overflow OR external. Acknowledging either source clears none of these flags.
- R12: A software write to a flag bit (other than a level-mode external flag) sets or clears the request just as a hardware event does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_n | input | 4 | External request pins 0..3, active low |
| tmr_ovf | input | 2 | Timer0 / timer1 rollover pulses |
| ser_rx_set | input | 1 | Serial receive-done pulse |
| ser_tx_set | input | 1 | Serial transmit-done pulse |
| t2_ovf_set | input | 1 | Timer2 overflow pulse |
| t2_ext_set | input | 1 | Timer2 external-event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_req | output | 1 | One-cycle vector request to the core |
| vec_addr | output | 8 | Vector address, held until acknowledge |
| vec_ack | input | 1 | Core acknowledge of the vector |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
The acknowledge that clears a timer flag can fall in the same cycle as a new rollover pulse for that timer. The bench drives `vec_ack` and `tmr_ovf[1]` high on the same edge, then reads the flag register. The flag must still read 1, and a second vector must follow once the level is retired. The acknowledge and a `reti` can also coincide in the in-service stack. That case is judged through nesting order: a blocked lower-level request is granted only after its enclosing levels have been retired.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 8;
    localparam int NEXT  = 4;
    localparam int NLVL  = 4;
    localparam int LVLW  = $clog2(NLVL);
    localparam int SRCW  = $clog2(NSRC);
    localparam int NFLAG = NSRC + 2;
    localparam int DW    = 8;
    localparam int AW    = 3;

    localparam int SRC_T0  = 1;
    localparam int SRC_T1  = 3;
    localparam int SRC_SER = 4;
    localparam int SRC_T2  = 5;
    localparam int F_RI    = 4;
    localparam int F_TI    = 5;
    localparam int F_TF2   = NSRC;
    localparam int F_EXF2  = NSRC + 1;

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    typedef struct packed {
        logic [NSRC-1:0]  en;
        logic             ea;
        logic [NEXT-1:0]  mode;
        logic [NSRC-1:0]  plo;
        logic [NSRC-1:0]  phi;
        logic [NFLAG-1:0] flag;
        logic [NLVL-1:0]  isr;
        st_e              st;
        logic [SRCW-1:0]  idx;
        logic [LVLW-1:0]  lvl;
        logic             vreq;
    } ctl_s;

    // source index (and flag bit) of each external input
    function automatic int ext_src(input int e);
        case (e)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq_ext_in.sv
module irq_ext_in (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic low_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_s;

    sync_s sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_n;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        sy_q <= sy_d;
    end

    assign low_o  = ~sy_q.s2;
    assign fall_o = sy_q.s3 & ~sy_q.s2;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] plo,
    input  logic [NSRC-1:0] phi,
    output logic            any_o,
    output logic [SRCW-1:0] idx_o,
    output logic [LVLW-1:0] lvl_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int l = NLVL - 1; l >= 0; l--) begin
            for (int i = 0; i < NSRC; i++) begin
                if (!any_o && req[i] && ({phi[i], plo[i]} == LVLW'(l))) begin
                    any_o = 1'b1;
                    idx_o = SRCW'(i);
                    lvl_o = LVLW'(l);
                end
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_n,
    input  logic [1:0]      tmr_ovf,
    input  logic            ser_rx_set,
    input  logic            ser_tx_set,
    input  logic            t2_ovf_set,
    input  logic            t2_ext_set,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            vec_req,
    output logic [DW-1:0]   vec_addr,
    input  logic            vec_ack,
    input  logic            reti
);
    ctl_s q, d;

    logic [NEXT-1:0] ext_low, ext_fall;
    logic [NSRC-1:0] req;
    logic            win_any;
    logic [SRCW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl;
    logic            ack_take;

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        irq_ext_in u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n  (ext_n[g]),
            .low_o  (ext_low[g]),
            .fall_o (ext_fall[g])
        );
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            if (i == SRC_SER)     req[i] = q.en[i] & (q.flag[F_RI] | q.flag[F_TI]);
            else if (i == SRC_T2) req[i] = q.en[i] & (q.flag[F_TF2] | q.flag[F_EXF2]);
            else                  req[i] = q.en[i] & q.flag[i];
        end
    end

    irq_pick u_pick (
        .req   (req),
        .plo   (q.plo),
        .phi   (q.phi),
        .any_o (win_any),
        .idx_o (win_idx),
        .lvl_o (win_lvl)
    );

    assign ack_take = vec_ack && (q.st == ST_WAIT);

    always_comb begin
        logic found;
        d      = q;
        d.vreq = 1'b0;
        found  = 1'b0;

        // clearing on acknowledge, lowest precedence
        if (ack_take) begin
            for (int e = 0; e < NEXT; e++)
                if (q.mode[e] && (int'(q.idx) == ext_src(e))) d.flag[ext_src(e)] = 1'b0;
            if (int'(q.idx) == SRC_T0) d.flag[SRC_T0] = 1'b0;
            if (int'(q.idx) == SRC_T1) d.flag[SRC_T1] = 1'b0;
        end

        // hardware events
        for (int e = 0; e < NEXT; e++)
            if (q.mode[e] && ext_fall[e]) d.flag[ext_src(e)] = 1'b1;
        if (tmr_ovf[0]) d.flag[SRC_T0] = 1'b1;
        if (tmr_ovf[1]) d.flag[SRC_T1] = 1'b1;
        if (ser_rx_set) d.flag[F_RI]   = 1'b1;
        if (ser_tx_set) d.flag[F_TI]   = 1'b1;
        if (t2_ovf_set) d.flag[F_TF2]  = 1'b1;
        if (t2_ext_set) d.flag[F_EXF2] = 1'b1;

        // software register writes
        if (reg_we) begin
            case (reg_addr)
                AW'(0): d.en = reg_wdata[NSRC-1:0];
                AW'(1): begin
                    d.ea   = reg_wdata[DW-1];
                    d.mode = reg_wdata[NEXT-1:0];
                end
                AW'(2): d.plo = reg_wdata[NSRC-1:0];
                AW'(3): d.phi = reg_wdata[NSRC-1:0];
                AW'(4): d.flag[NSRC-1:0] = reg_wdata[NSRC-1:0];
                AW'(5): begin
                    d.flag[F_TF2]  = reg_wdata[0];
                    d.flag[F_EXF2] = reg_wdata[1];
                end
                default: ;
            endcase
        end

        // level-mode external flags follow the pin
        for (int e = 0; e < NEXT; e++)
            if (!q.mode[e]) d.flag[ext_src(e)] = ext_low[e];

        // in-service stack
        if (reti) begin
            for (int l = NLVL - 1; l >= 0; l--) begin
                if (!found && q.isr[l]) begin
                    d.isr[l] = 1'b0;
                    found    = 1'b1;
                end
            end
        end

        // handshake
        if (ack_take) begin
            d.isr[q.lvl] = 1'b1;
            d.st         = ST_IDLE;
        end else if (q.st == ST_IDLE && q.ea && win_any &&
                     ((q.isr >> win_lvl) == '0)) begin
            d.st   = ST_WAIT;
            d.idx  = win_idx;
            d.lvl  = win_lvl;
            d.vreq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(0): reg_rdata[NSRC-1:0] = q.en;
            AW'(1): begin
                reg_rdata[DW-1]     = q.ea;
                reg_rdata[NEXT-1:0] = q.mode;
            end
            AW'(2): reg_rdata[NSRC-1:0] = q.plo;
            AW'(3): reg_rdata[NSRC-1:0] = q.phi;
            AW'(4): reg_rdata[NSRC-1:0] = q.flag[NSRC-1:0];
            AW'(5): reg_rdata[1:0]      = {q.flag[F_EXF2], q.flag[F_TF2]};
            default: ;
        endcase
    end

    assign vec_req  = q.vreq;
    assign vec_addr = DW'(VEC_BASE) + DW'(q.idx) * DW'(VEC_STEP);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          vec_req,
    input logic          vec_ack,
    input logic          reti,
    input logic [1:0]    tmr_ovf,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input ctl_s          cq
);
    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(cq.ea));

    assert_tf0_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && cq.st == ST_WAIT && int'(cq.idx) == SRC_T0 && !tmr_ovf[0] &&
         !(reg_we && reg_addr == AW'(4))) |=> !cq.flag[SRC_T0]);

    assert_reti_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(vec_ack && cq.st == ST_WAIT) && cq.isr != '0) |=>
        ($countones(cq.isr) + 1 == $past($countones(cq.isr))));

    assert_nest_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (($past(cq.isr) >> cq.lvl) == '0));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_req  (vec_req),
    .vec_ack  (vec_ack),
    .reti     (reti),
    .tmr_ovf  (tmr_ovf),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .cq       (q)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // en, plo, phi, flags lo, flags hi, expected vector (0 = none)
    localparam logic [47:0] TBL [NV] = '{
        {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h03},
        {8'hFE, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h0B},
        {8'hFF, 8'h00, 8'h00, 8'h82, 8'h00, 8'h0B},
        {8'hFF, 8'h80, 8'h00, 8'h83, 8'h00, 8'h3B},
        {8'hFF, 8'h00, 8'h40, 8'hC1, 8'h00, 8'h33},
        {8'hFF, 8'h40, 8'h20, 8'h40, 8'h01, 8'h2B},
        {8'h10, 8'h00, 8'h00, 8'h20, 8'h00, 8'h23},
        {8'hFF, 8'hFF, 8'hFF, 8'h08, 8'h00, 8'h1B},
        {8'h04, 8'h00, 8'h00, 8'h04, 8'h00, 8'h13},
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00}
    };

    logic       clk = 0, rst_n = 0;
    logic [3:0] ext_n = 4'hF;
    logic [1:0] tmr_ovf = 0;
    logic       ser_rx_set = 0, ser_tx_set = 0, t2_ovf_set = 0, t2_ext_set = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       vec_req;
    logic [7:0] vec_addr;
    logic       vec_ack = 0, reti = 0;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set),
        .t2_ovf_set(t2_ovf_set), .t2_ext_set(t2_ext_set),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_req(vec_req), .vec_addr(vec_addr),
        .vec_ack(vec_ack), .reti(reti)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    // counts vector pulses over a window, keeps the first address
    task automatic wait_vec(output int cnt, output logic [7:0] va);
        cnt = 0; va = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (vec_req) begin
                if (cnt == 0) va = vec_addr;
                cnt++;
            end
        end
    endtask

    task automatic ack();
        @(negedge clk); vec_ack = 1;
        @(negedge clk); vec_ack = 0;
    endtask

    task automatic ret();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic clean();
        wr(1, 8'h00); ret(); ret(); ret(); ret();
        wr(0, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n; logic [7:0] va, v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk(vec_req == 0, "R1 vec_req", vec_req, 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 reg reset", v, 0);
        end

        // R2 register readback
        wr(0, 8'h5A); wr(2, 8'hC3); wr(3, 8'h3C); wr(1, 8'h0B);
        rd(0, v); chk(v == 8'h5A, "R2 enable", v, 8'h5A);
        rd(2, v); chk(v == 8'hC3, "R2 prio lo", v, 8'hC3);
        rd(3, v); chk(v == 8'h3C, "R2 prio hi", v, 8'h3C);
        rd(1, v); chk(v == 8'h0B, "R2 ctrl", v, 8'h0B);
        wr(5, 8'h03); rd(5, v); chk(v == 8'h03, "R2 R12 flags hi", v, 8'h03);
        clean();

        // R4 R5 R12 R3: table walk with software-set flags
        for (int k = 0; k < NV; k++) begin
            wr(1, 8'h0F);
            wr(0, TBL[k][47:40]); wr(2, TBL[k][39:32]); wr(3, TBL[k][31:24]);
            wr(4, TBL[k][23:16]); wr(5, TBL[k][15:8]);
            wr(1, 8'h8F);
            wait_vec(n, va);
            if (TBL[k][7:0] == 0) chk(n == 0, "R3 disabled source", n, 0);
            else chk(n == 1 && va == TBL[k][7:0], "R4 R5 R12 vector", va, TBL[k][7:0]);
            wr(1, 8'h0F);
            if (n != 0) ack();
            clean();
        end

        // R3 global enable off blocks
        wr(1, 8'h0F); wr(0, 8'hFF); wr(4, 8'h02);
        wait_vec(n, va); chk(n == 0, "R3 global enable", n, 0);
        clean();

        // R7 handshake: single pulse, no clear until ack
        wr(1, 8'h0F); wr(0, 8'h02); wr(4, 8'h02); wr(1, 8'h8F);
        wait_vec(n, va); chk(n == 1 && va == 8'h0B, "R7 single pulse", n, 1);
        rd(4, v); chk(v[1] == 1, "R7 flag held before ack", v[1], 1);
        ack();
        rd(4, v); chk(v[1] == 0, "R7 R10 flag cleared on ack", v[1], 0);
        clean();

        // R6 nesting
        wr(1, 8'h0F); wr(0, 8'hFF); wr(2, 8'h0A); wr(3, 8'h40);
        wr(4, 8'h02); wr(1, 8'h8F);
        wait_vec(n, va); chk(va == 8'h0B, "R6 first level", va, 8'h0B);
        ack();
        wr(4, 8'h08);
        wait_vec(n, va); chk(n == 0, "R6 same level blocked", n, 0);
        wr(4, 8'h48);
        wait_vec(n, va); chk(n == 1 && va == 8'h33, "R6 higher nests", va, 8'h33);
        ack(); ret();
        wait_vec(n, va); chk(n == 0, "R6 still in service", n, 0);
        ret();
        wait_vec(n, va); chk(n == 1 && va == 8'h1B, "R6 after second reti", va, 8'h1B);
        ack();
        clean();

        // R10 ack and rollover in the same cycle
        wr(0, 8'h08); wr(1, 8'h80);
        @(negedge clk); tmr_ovf[1] = 1; @(negedge clk); tmr_ovf[1] = 0;
        wait_vec(n, va); chk(n == 1 && va == 8'h1B, "R10 timer1 vector", va, 8'h1B);
        @(negedge clk); vec_ack = 1; tmr_ovf[1] = 1;
        @(negedge clk); vec_ack = 0; tmr_ovf[1] = 0;
        rd(4, v); chk(v[3] == 1, "R10 set beats ack clear", v[3], 1);
        ret();
        wait_vec(n, va); chk(n == 1 && va == 8'h1B, "R10 second vector", va, 8'h1B);
        ack(); clean();

        // R8 edge mode on ext1
        wr(0, 8'h04); wr(1, 8'h82);
        @(negedge clk); ext_n[1] = 0;
        wait_vec(n, va); chk(n == 1 && va == 8'h13, "R8 edge vector", va, 8'h13);
        rd(4, v); chk(v[2] == 1, "R8 flag latched", v[2], 1);
        ack();
        rd(4, v); chk(v[2] == 0, "R8 flag cleared on ack", v[2], 0);
        ret();
        wait_vec(n, va); chk(n == 0, "R8 held low no repeat", n, 0);
        ext_n[1] = 1; clean();

        // R9 level mode on ext0
        wr(0, 8'h01); wr(1, 8'h80);
        @(negedge clk); ext_n[0] = 0;
        wait_vec(n, va); chk(n == 1 && va == 8'h03, "R9 level vector", va, 8'h03);
        wr(1, 8'h00); ack();
        rd(4, v); chk(v[0] == 1, "R9 not cleared by ack", v[0], 1);
        @(negedge clk); ext_n[0] = 1;
        repeat (4) @(negedge clk);
        rd(4, v); chk(v[0] == 0, "R9 follows pin high", v[0], 0);
        wr(4, 8'h01); rd(4, v); chk(v[0] == 0, "R9 write ignored", v[0], 0);
        clean();

        // R11 serial and timer2 flags survive ack
        wr(0, 8'h10); wr(1, 8'h80);
        @(negedge clk); ser_rx_set = 1; @(negedge clk); ser_rx_set = 0;
        wait_vec(n, va); chk(n == 1 && va == 8'h23, "R11 serial vector", va, 8'h23);
        wr(1, 8'h00); ack();
        rd(4, v); chk(v[4] == 1, "R11 receive flag kept", v[4], 1);
        clean();
        wr(0, 8'h20);
        @(negedge clk); t2_ext_set = 1; @(negedge clk); t2_ext_set = 0;
        wr(1, 8'h80);
        wait_vec(n, va); chk(n == 1 && va == 8'h2B, "R11 timer2 vector", va, 8'h2B);
        wr(1, 8'h00); ack();
        rd(5, v); chk(v == 8'h02, "R11 timer2 flag kept", v, 8'h02);
        clean();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule